// File: doc/BRIEF.md
# Scaled-Index Load Address Generator

This unit forms the effective address of an indexed load in which the index operand is shifted left before it is added to the base operand. It receives the operand values that the register file has already read, the base and target register numbers, a two-bit scale field and a flag that marks the update form. One clock later it presents the address, a request to write that address back into the base register, and a flag for an update form whose register numbers are not allowed. The register file itself and the memory access are outside this block.

The scale field selects a left shift of one to four bit positions. In the plain form a base register number of zero stands for a literal zero operand. In the update form the base operand is always the value read from the named register, and the address is written back into that register when the form is legal. Every result is registered and qualified by a valid bit that trails the input valid bit by one cycle.

Top module: `scaled_index_agen`

## Requirements
- R1: One cycle after an accepted input, `eff_addr` equals the base term plus `index_val` shifted left by (`shift_sel` + 1) bit positions.
- R2: `shift_sel` values 0, 1, 2 and 3 select left shifts of 1, 2, 3 and 4 bit positions.
- R3: With `update_form` = 0 and `base_reg` = 0, the base term is zero whatever `base_val` holds.
- R4: With `update_form` = 1, or with `base_reg` nonzero, the base term is `base_val`.
- R5: An update form with `base_reg` nonzero and `base_reg` different from `target_reg` gives `wb_en` = 1, `wb_data` equal to `eff_addr` and `illegal` = 0.
- R6: An update form with `base_reg` = 0 or `base_reg` = `target_reg` gives `illegal` = 1 and `wb_en` = 0.
- R7: A plain form (`update_form` = 0) gives `wb_en` = 0 and `illegal` = 0.
- R8: `out_valid` equals `in_valid` of the previous cycle, and `wb_en` and `illegal` are 0 in any cycle where `out_valid` is 0.
- R9: While `rst_n` is low, `out_valid`, `wb_en` and `illegal` are 0.
- R10: The addition and the shift are carried out modulo 2^64; bits carried or shifted beyond bit 63 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input operands are present |
| base_val | input | 64 | Value read from the base register |
| base_reg | input | 5 | Base register number |
| index_val | input | 64 | Value read from the index register |
| shift_sel | input | 2 | Scale field, shift = value + 1 |
| update_form | input | 1 | Address is to be written back to the base register |
| target_reg | input | 5 | Destination register number of the load |
| out_valid | output | 1 | Outputs below belong to an accepted input |
| eff_addr | output | 64 | Effective address |
| wb_en | output | 1 | Write `wb_data` into the base register |
| wb_data | output | 64 | New base register value |
| illegal | output | 1 | Update form with disallowed register numbers |

## Verification
The assertions assume only that the inputs are stable binary values sampled at each rising edge; they make no assumption about how register numbers relate, since the block must classify every combination itself. The stimulus draws register numbers from a small range so that a zero base register and equal base and target numbers occur often, mixes idle cycles between accepted inputs, and adds directed all-ones operands to force the carry and shift wrap.

// File: rtl/scaled_index_agen.sv
module scaled_index_agen #(
  parameter int XLEN = 64,
  parameter int SHW  = 2,
  parameter int RNW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] base_val,
  input  logic [RNW-1:0]  base_reg,
  input  logic [XLEN-1:0] index_val,
  input  logic [SHW-1:0]  shift_sel,
  input  logic            update_form,
  input  logic [RNW-1:0]  target_reg,
  output logic            out_valid,
  output logic [XLEN-1:0] eff_addr,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal
);

  localparam int SAW = SHW + 1;

  logic [SAW-1:0]  shift_by;
  logic [XLEN-1:0] base_term;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] sum;
  logic            base_zero;
  logic            upd_ok;

  assign base_zero = (base_reg == '0);
  assign shift_by  = {1'b0, shift_sel} + SAW'(1);
  assign base_term = (!update_form && base_zero) ? '0 : base_val;
  assign scaled    = index_val << shift_by;
  assign sum       = base_term + scaled;
  assign upd_ok    = !base_zero && (base_reg != target_reg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && update_form && upd_ok;
      illegal   <= in_valid && update_form && !upd_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) eff_addr <= sum;
  end

  assign wb_data = eff_addr;

  assert_wb_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && illegal));

  assert_flags_need_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || illegal) |-> out_valid);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_zero_base_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && update_form && base_reg == '0) |=> (illegal && !wb_en));

  assert_plain_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !update_form) |=> (!wb_en && !illegal));

  assert_zero_base_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !update_form && base_reg == '0) |=>
      (eff_addr == ($past(index_val) << ($past(shift_sel) + 3'd1))));

  assert_wb_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data == eff_addr));

endmodule

// File: tb/test_scaled_index_agen.sv
`timescale 1ns/1ps
module test_scaled_index_agen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] base_val = '0;
  logic [4:0]  base_reg = '0;
  logic [63:0] index_val = '0;
  logic [1:0]  shift_sel = '0;
  logic        update_form = 1'b0;
  logic [4:0]  target_reg = '0;
  logic        out_valid;
  logic [63:0] eff_addr;
  logic        wb_en;
  logic [63:0] wb_data;
  logic        illegal;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scaled_index_agen i_scaled_index_agen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .base_reg(base_reg), .index_val(index_val), .shift_sel(shift_sel),
    .update_form(update_form), .target_reg(target_reg), .out_valid(out_valid),
    .eff_addr(eff_addr), .wb_en(wb_en), .wb_data(wb_data), .illegal(illegal)
  );

  function automatic logic [63:0] exp_addr(logic [63:0] b, logic [4:0] br,
      logic [63:0] x, logic [1:0] s, logic u);
    logic [63:0] bt;
    bt = (!u && br == 0) ? 64'd0 : b;
    return bt + (x << (int'(s) + 1));
  endfunction

  function automatic logic exp_ok(logic [4:0] br, logic [4:0] tr);
    return (br != 0) && (br != tr);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_one(logic v, logic [63:0] b, logic [4:0] br, logic [63:0] x,
      logic [1:0] s, logic u, logic [4:0] tr, string tag);
    logic [63:0] ea;
    logic ok;
    in_valid = v; base_val = b; base_reg = br; index_val = x;
    shift_sel = s; update_form = u; target_reg = tr;
    @(posedge clk);
    @(negedge clk);
    ea = exp_addr(b, br, x, s, u);
    ok = exp_ok(br, tr);
    check({tag, " R8 valid"}, 64'(out_valid), 64'(v));
    if (v) begin
      check({tag, " R1 addr"}, eff_addr, ea);
      check({tag, " R5 wb_en"}, 64'(wb_en), 64'(u && ok));
      check({tag, " R6 illegal"}, 64'(illegal), 64'(u && !ok));
      if (u && ok) check({tag, " R5 wb_data"}, wb_data, ea);
      if (!u) check({tag, " R7 plain"}, 64'({wb_en, illegal}), 64'd0);
    end else begin
      check({tag, " R8 idle flags"}, 64'({wb_en, illegal}), 64'd0);
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_2024;
    void'($urandom(seed));
    @(negedge clk);
    in_valid = 1'b1; update_form = 1'b1; base_reg = 5'd3;
    @(negedge clk);
    check("R9 reset valid", 64'(out_valid), 64'd0);
    check("R9 reset flags", 64'({wb_en, illegal}), 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 4; s++)
      run_one(1, 64'h1000, 5'd2, 64'h1, 2'(s), 0, 5'd7, $sformatf("R2 shift%0d", s));
    run_one(1, 64'hdead_beef, 5'd0, 64'h10, 2'd1, 0, 5'd4, "R3 zero base");
    run_one(1, 64'h4000, 5'd0, 64'h10, 2'd0, 1, 5'd4, "R4 R6 upd base0");
    run_one(1, 64'h4000, 5'd9, 64'h10, 2'd2, 1, 5'd9, "R6 base eq tgt");
    run_one(1, 64'h4000, 5'd9, 64'h10, 2'd3, 1, 5'd8, "R4 R5 legal upd");
    run_one(1, '1, 5'd1, '1, 2'd3, 0, 5'd2, "R10 wrap");
    run_one(1, 64'h8000_0000_0000_0000, 5'd1, 64'h8000_0000_0000_0000, 2'd0, 1, 5'd2, "R10 top");
    run_one(0, 64'h1, 5'd1, 64'h1, 2'd0, 1, 5'd2, "R8 idle");

    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom % 5) != 0;
      run_one(v, {$urandom, $urandom}, 5'($urandom % 4), {$urandom, $urandom},
              2'($urandom), 1'($urandom), 5'($urandom % 4), "R1 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule